// File: doc/BRIEF.md
# Three-Channel Square Tone, Noise and Mixer Core

This block makes the raw sound of a programmable sound generator. Three independent tone channels each divide a shared clock-enable down to a square wave whose period is set by a 12-bit value. One noise source, a 17-bit pseudo-random shift register stepped at its own programmable rate, is shared by all three channels. For each channel, a mixer control register decides whether the square wave, the noise, both or neither gate that channel. A level register then gives the channel a 5-bit amplitude code. The code is either a fixed level or the value presented on an external envelope input.

A CPU programs the block through a single register port. It holds a write strobe, an address and write data, and reads back the addressed register combinationally, so reading never alters sound. Register 7 also holds two port-direction bits. They are brought out as plain outputs and take no part in sound generation. The amplitude codes go on to a logarithmic converter outside this block.

Each tone channel is a two-state machine with states TONE_LOW and TONE_HIGH. The transition TONE_LOW→TONE_HIGH and TONE_HIGH→TONE_LOW is taken on a counter expiry. The noise stepper is a two-state machine with states NZ_FIRST_HALF and NZ_SECOND_HALF. The transition NZ_FIRST_HALF→NZ_SECOND_HALF is taken on an expiry without a shift. The transition NZ_SECOND_HALF→NZ_FIRST_HALF is taken on an expiry and shifts the register once.

Top module: `psg_tone_mixer`

## Requirements
- R1: Reset state. After reset every register reads 0, all amplitude outputs are 0 and both direction outputs are 0. The noise register holds the seed value 1.
- R2: Tone period. A clock-enable occurs once every 8 clocks. Channel n (n = 0, 1, 2 for A, B, C) has a tone period TP = {register 2n+1 bits 3..0, register 2n}. Its square wave stays 8×TP clocks in each half, so one full cycle is 16×TP clocks.
- R3: Zero periods. A tone period of 0 behaves as a period of 1, and so does a noise period of 0.
- R4: Noise source. The noise source is a 17-bit shift register that shifts right once every 16×NP clocks, where NP is register 6 bits 4..0. On each shift, bit0 XOR bit2 enters bit 16. Bit0 is the noise output.
- R5: Mixer. In register 7, bit n disables tone and bit n+3 disables noise for channel n (a 1 disables). The mixed output is (tone OR tone-disable) AND (noise OR noise-disable). The amplitude is 0 whenever the mixed output is low.
- R6: Level mode. Level registers 8, 9 and 10 serve channels A, B and C. When bit 4 is 0 and the mixed output is high, the amplitude is {bits 3..0, 1}. When bit 4 is 1, the amplitude is the env_level input and bits 3..0 are ignored.
- R7: Direction bits. Register 7 bit 6 drives port_a_out and bit 7 drives port_b_out (1 selects output). Neither bit changes any amplitude.
- R8: Readback. reg_rdata shows the addressed register with its unused bits as 0: coarse registers use bits 3..0, the noise and level registers use bits 4..0, and the mixer uses all 8 bits. Addresses 11 to 15 read 0 and ignore writes. Reading never changes the sound.
- R9: Write timing. A register write is applied at the clock edge where it is presented. Counters that step on that same edge still use the old value. A shortened period whose counter already stands at or beyond the new limit expires on the next clock-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and readback |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational readback of the addressed register |
| env_level | input | 5 | Envelope amplitude used by channels in envelope mode |
| amp_a | output | 5 | Channel A amplitude code |
| amp_b | output | 5 | Channel B amplitude code |
| amp_c | output | 5 | Channel C amplitude code |
| port_a_out | output | 1 | Direction bit for I/O port A (1 = output) |
| port_b_out | output | 1 | Direction bit for I/O port B (1 = output) |

## Verification
Two events can fall on the same clock edge: a CPU write to a period register, and the clock-enable that steps the counters using that register. The bench provokes this collision by writing a shorter tone period at each of the eight prescaler phases in turn. A behavioural model applies the counter step with the old register contents before committing the write. The model is compared with every amplitude and with readback on every clock, so an early or late application of the write shows up as a mismatch at the next toggle. Readback sweeps run while tones play to show that reads and sound do not interfere.

// File: rtl/psg_pkg.sv
package psg_pkg;
    localparam int PSG_CHANS   = 3;
    localparam int FINE_W      = 8;
    localparam int COARSE_W    = 4;
    localparam int TONE_W      = FINE_W + COARSE_W;
    localparam int NOISE_W     = 5;
    localparam int LFSR_W      = 17;
    localparam int LVL_W       = 4;
    localparam int AMP_W       = LVL_W + 1;
    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 8;
    localparam int PRESCALE    = 8;

    localparam int REG_NOISE   = 2 * PSG_CHANS;
    localparam int REG_MIXER   = REG_NOISE + 1;
    localparam int REG_LEVEL0  = REG_MIXER + 1;
    localparam int MIX_DIR_A   = 2 * PSG_CHANS;
    localparam int MIX_DIR_B   = MIX_DIR_A + 1;

    typedef enum logic {
        TONE_LOW,
        TONE_HIGH
    } tone_state_t;

    typedef enum logic {
        NZ_FIRST_HALF,
        NZ_SECOND_HALF
    } noise_state_t;
endpackage

// File: rtl/psg_prescaler.sv
module psg_prescaler #(
    parameter int DIV = psg_pkg::PRESCALE
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/psg_regfile.sv
module psg_regfile
    import psg_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wdata,
    output logic [DATA_W-1:0]                   rdata,
    output logic [PSG_CHANS-1:0][TONE_W-1:0]    tone_period,
    output logic [NOISE_W-1:0]                  noise_period,
    output logic [DATA_W-1:0]                   mixer,
    output logic [PSG_CHANS-1:0][AMP_W-1:0]     level
);
    logic [PSG_CHANS-1:0][FINE_W-1:0]   fine_q;
    logic [PSG_CHANS-1:0][COARSE_W-1:0] coarse_q;
    logic [NOISE_W-1:0]                 noise_q;
    logic [DATA_W-1:0]                  mixer_q;
    logic [PSG_CHANS-1:0][AMP_W-1:0]    level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine_q   <= '0;
            coarse_q <= '0;
            noise_q  <= '0;
            mixer_q  <= '0;
            level_q  <= '0;
        end else if (we) begin
            for (int ch = 0; ch < PSG_CHANS; ch++) begin
                if (addr == ADDR_W'(2 * ch))
                    fine_q[ch] <= wdata;
                if (addr == ADDR_W'(2 * ch + 1))
                    coarse_q[ch] <= wdata[COARSE_W-1:0];
                if (addr == ADDR_W'(REG_LEVEL0 + ch))
                    level_q[ch] <= wdata[AMP_W-1:0];
            end
            if (addr == ADDR_W'(REG_NOISE))
                noise_q <= wdata[NOISE_W-1:0];
            if (addr == ADDR_W'(REG_MIXER))
                mixer_q <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < PSG_CHANS; ch++) begin
            if (addr == ADDR_W'(2 * ch))
                rdata = fine_q[ch];
            if (addr == ADDR_W'(2 * ch + 1))
                rdata = DATA_W'(coarse_q[ch]);
            if (addr == ADDR_W'(REG_LEVEL0 + ch))
                rdata = DATA_W'(level_q[ch]);
        end
        if (addr == ADDR_W'(REG_NOISE))
            rdata = DATA_W'(noise_q);
        if (addr == ADDR_W'(REG_MIXER))
            rdata = mixer_q;
    end

    always_comb begin
        for (int ch = 0; ch < PSG_CHANS; ch++) begin
            tone_period[ch] = {coarse_q[ch], fine_q[ch]};
        end
    end

    assign noise_period = noise_q;
    assign mixer        = mixer_q;
    assign level        = level_q;
endmodule

// File: rtl/psg_tone_chan.sv
module psg_tone_chan
    import psg_pkg::*;
#(
    parameter int TW = TONE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [TW-1:0] period,
    output logic          sq
);
    tone_state_t   state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] limit;
    logic          expire;

    always_comb begin
        limit  = (period == '0) ? TW'(1) : period;
        expire = tick && (cnt_q >= limit - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TONE_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (tick) begin
            cnt_d = expire ? '0 : cnt_q + 1'b1;
        end
        if (expire) begin
            unique case (state_q)
                TONE_LOW:  state_d = TONE_HIGH;
                TONE_HIGH: state_d = TONE_LOW;
                default:   state_d = TONE_LOW;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            TONE_LOW:  sq = 1'b0;
            TONE_HIGH: sq = 1'b1;
            default:   sq = 1'b0;
        endcase
    end
endmodule

// File: rtl/psg_noise_gen.sv
module psg_noise_gen
    import psg_pkg::*;
#(
    parameter int               NW   = NOISE_W,
    parameter int               LW   = LFSR_W,
    parameter logic [LW-1:0]    SEED = LW'(1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [NW-1:0] period,
    output logic          noise,
    output logic [LW-1:0] lfsr
);
    noise_state_t  state_q, state_d;
    logic [NW-1:0] cnt_q, cnt_d;
    logic [NW-1:0] limit;
    logic [LW-1:0] lfsr_q, lfsr_d;
    logic          expire;

    always_comb begin
        limit  = (period == '0) ? NW'(1) : period;
        expire = tick && (cnt_q >= limit - 1'b1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NZ_FIRST_HALF;
            cnt_q   <= '0;
            lfsr_q  <= SEED;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lfsr_q  <= lfsr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lfsr_d  = lfsr_q;
        if (tick) begin
            cnt_d = expire ? '0 : cnt_q + 1'b1;
        end
        if (expire) begin
            unique case (state_q)
                NZ_FIRST_HALF: begin
                    state_d = NZ_SECOND_HALF;
                end
                NZ_SECOND_HALF: begin
                    state_d = NZ_FIRST_HALF;
                    lfsr_d  = {lfsr_q[0] ^ lfsr_q[2], lfsr_q[LW-1:1]};
                end
                default: state_d = NZ_FIRST_HALF;
            endcase
        end
    end

    assign noise = lfsr_q[0];
    assign lfsr  = lfsr_q;
endmodule

// File: rtl/psg_tone_mixer.sv
module psg_tone_mixer
    import psg_pkg::*;
#(
    parameter int            PRESCALE_DIV = PRESCALE,
    parameter logic [16:0]   NOISE_SEED   = 17'h00001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [AMP_W-1:0]    env_level,
    output logic [AMP_W-1:0]    amp_a,
    output logic [AMP_W-1:0]    amp_b,
    output logic [AMP_W-1:0]    amp_c,
    output logic                port_a_out,
    output logic                port_b_out
);
    logic                              tick;
    logic [PSG_CHANS-1:0][TONE_W-1:0]  tone_period;
    logic [NOISE_W-1:0]                noise_period;
    logic [DATA_W-1:0]                 mixer_q;
    logic [PSG_CHANS-1:0][AMP_W-1:0]   level_q;
    logic [PSG_CHANS-1:0]              tone_sq;
    logic [PSG_CHANS-1:0]              mixed;
    logic [PSG_CHANS-1:0][AMP_W-1:0]   amp_vec;
    logic                              noise_bit;
    logic [LFSR_W-1:0]                 lfsr_q;

    psg_prescaler #(.DIV(PRESCALE_DIV)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    psg_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .tone_period (tone_period),
        .noise_period(noise_period),
        .mixer       (mixer_q),
        .level       (level_q)
    );

    psg_noise_gen #(.NW(NOISE_W), .LW(LFSR_W), .SEED(NOISE_SEED)) u_noise (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .period(noise_period),
        .noise (noise_bit),
        .lfsr  (lfsr_q)
    );

    for (genvar ch = 0; ch < PSG_CHANS; ch++) begin : g_chan
        psg_tone_chan #(.TW(TONE_W)) u_tone (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .period(tone_period[ch]),
            .sq    (tone_sq[ch])
        );

        assign mixed[ch] = (tone_sq[ch] | mixer_q[ch]) &
                           (noise_bit   | mixer_q[PSG_CHANS + ch]);

        always_comb begin
            if (!mixed[ch])
                amp_vec[ch] = '0;
            else if (level_q[ch][LVL_W])
                amp_vec[ch] = env_level;
            else
                amp_vec[ch] = {level_q[ch][LVL_W-1:0], 1'b1};
        end
    end

    assign amp_a      = amp_vec[0];
    assign amp_b      = amp_vec[1];
    assign amp_c      = amp_vec[2];
    assign port_a_out = mixer_q[MIX_DIR_A];
    assign port_b_out = mixer_q[MIX_DIR_B];
endmodule

// File: rtl/psg_tone_mixer_chk.sv
module psg_tone_mixer_chk
    import psg_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick,
    input logic [PSG_CHANS-1:0]  tone_sq,
    input logic [LFSR_W-1:0]     lfsr_q,
    input logic [DATA_W-1:0]     mixer_q,
    input logic [AMP_W-1:0]      lvl_a,
    input logic [AMP_W-1:0]      env_level,
    input logic [AMP_W-1:0]      amp_a
);
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    p_tone_hold_off_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(tone_sq));

    p_lfsr_hold_off_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(lfsr_q));

    p_lfsr_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_q != $past(lfsr_q)) |->
            (lfsr_q[LFSR_W-2:0] == $past(lfsr_q[LFSR_W-1:1]) &&
             lfsr_q[LFSR_W-1] == ($past(lfsr_q[0]) ^ $past(lfsr_q[2]))));

    p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    p_silent_tone_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mixer_q[0] && !tone_sq[0]) |-> (amp_a == '0));

    p_fixed_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_a[LVL_W] && amp_a != '0) |-> (amp_a == {lvl_a[LVL_W-1:0], 1'b1}));

    p_env_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_a[LVL_W] && amp_a != '0) |-> (amp_a == env_level));
endmodule

bind psg_tone_mixer psg_tone_mixer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .tone_sq  (tone_sq),
    .lfsr_q   (lfsr_q),
    .mixer_q  (mixer_q),
    .lvl_a    (level_q[0]),
    .env_level(env_level),
    .amp_a    (amp_a)
);

// File: tb/test_psg_tone_mixer.sv
module test_psg_tone_mixer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] env_level = '0;
    logic [4:0] amp_a, amp_b, amp_c;
    logic       port_a_out, port_b_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #4 clk = ~clk;

    psg_tone_mixer i_psg_tone_mixer (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .env_level (env_level),
        .amp_a     (amp_a),
        .amp_b     (amp_b),
        .amp_c     (amp_c),
        .port_a_out(port_a_out),
        .port_b_out(port_b_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    int       m_pc;
    int       m_cnt[3];
    bit       m_sq[3];
    int       m_ncnt;
    bit       m_nhalf;
    int       m_lfsr;
    logic [7:0] m_reg[16];

    function automatic logic [7:0] reg_mask(input int a);
        if (a <= 5) return (a % 2 == 0) ? 8'hFF : 8'h0F;
        if (a == 6) return 8'h1F;
        if (a == 7) return 8'hFF;
        if (a <= 10) return 8'h1F;
        return 8'h00;
    endfunction

    function automatic int exp_amp(input int ch);
        bit mix;
        mix = (m_sq[ch] | m_reg[7][ch]) & ((m_lfsr & 1) != 0 | m_reg[7][ch + 3]);
        if (!mix) return 0;
        if (m_reg[8 + ch][4]) return int'(env_level);
        return int'({m_reg[8 + ch][3:0], 1'b1});
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_pc = 0; m_ncnt = 0; m_nhalf = 0; m_lfsr = 1;
            for (int i = 0; i < 3; i++) begin m_cnt[i] = 0; m_sq[i] = 0; end
            for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
        end else begin
            bit tk;
            tk = (m_pc == 7);
            m_pc = (m_pc + 1) % 8;
            if (tk) begin
                for (int ch = 0; ch < 3; ch++) begin
                    int p;
                    p = int'(m_reg[2 * ch]) + 256 * int'(m_reg[2 * ch + 1] & 8'h0F);
                    if (p == 0) p = 1;
                    if (m_cnt[ch] + 1 >= p) begin m_cnt[ch] = 0; m_sq[ch] = !m_sq[ch]; end
                    else m_cnt[ch]++;
                end
                begin
                    int np;
                    np = int'(m_reg[6] & 8'h1F);
                    if (np == 0) np = 1;
                    if (m_ncnt + 1 >= np) begin
                        m_ncnt = 0;
                        if (m_nhalf) begin
                            int nb;
                            nb = (m_lfsr & 1) ^ ((m_lfsr >> 2) & 1);
                            m_lfsr = (m_lfsr >> 1) | (nb << 16);
                        end
                        m_nhalf = !m_nhalf;
                    end else m_ncnt++;
                end
            end
            if (reg_we && reg_addr <= 4'd10)
                m_reg[reg_addr] = reg_wdata & reg_mask(int'(reg_addr));
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(amp_a == 5'(exp_amp(0)), cur_req, "amp_a", amp_a, exp_amp(0));
            chk(amp_b == 5'(exp_amp(1)), cur_req, "amp_b", amp_b, exp_amp(1));
            chk(amp_c == 5'(exp_amp(2)), cur_req, "amp_c", amp_c, exp_amp(2));
            chk(reg_rdata == m_reg[reg_addr], "R8", "reg_rdata", reg_rdata, m_reg[reg_addr]);
            chk({port_b_out, port_a_out} == {m_reg[7][7], m_reg[7][6]}, "R7", "port dirs",
                {port_b_out, port_a_out}, {m_reg[7][7], m_reg[7][6]});
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string req);
        @(posedge clk); #1;
        reg_addr = 4'(a);
        @(negedge clk);
        chk(reg_rdata == 8'(exp), req, $sformatf("readback addr %0d", a), reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic next_edge(input bit rising, output int at);
        bit prev, cur;
        at = -1;
        @(negedge clk);
        prev = (amp_a != 0);
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            cur = (amp_a != 0);
            if (rising ? (cur && !prev) : (!cur && prev)) begin at = cyc; return; end
            prev = cur;
        end
    endtask

    task automatic measure(input int half, input string req);
        int r1, f1, r2;
        next_edge(1'b1, r1);
        next_edge(1'b0, f1);
        next_edge(1'b1, r2);
        chk(f1 - r1 == half, req, "high half length", f1 - r1, half);
        chk(r2 - r1 == 2 * half, req, "full cycle length", r2 - r1, 2 * half);
    endtask

    initial begin
        #200000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        @(negedge clk);
        chk(amp_a == 0 && amp_b == 0 && amp_c == 0, "R1", "amps after reset", amp_a, 0);
        chk(port_a_out == 0 && port_b_out == 0, "R1", "dirs after reset", port_a_out, 0);
        for (int a = 0; a < 16; a++) rd_chk(a, 0, "R1");

        // R2: tone period, tone A only, fixed level 15
        cur_req = "R2";
        wr(7, 8'h3E); wr(8, 8'h0F); wr(9, 8'h03); wr(10, 8'h07);
        wr(0, 3); wr(1, 0);
        measure(8 * 3, "R2");
        wr(0, 8'h01); wr(1, 8'hF1);
        measure(8 * 257, "R2");
        wr(1, 0); wr(0, 5);
        measure(8 * 5, "R2");

        // R3: zero tone period behaves as one
        cur_req = "R3";
        wr(0, 0);
        measure(8, "R3");
        wr(0, 1);
        measure(8, "R3");

        // R8: readback sweep during sound, masked bits
        cur_req = "R8";
        wr(2, 7); wr(4, 9);
        for (int k = 0; k < 200; k++) begin
            @(posedge clk); #1 reg_addr = 4'(k % 16);
        end
        wr(1, 8'hFF); rd_chk(1, 8'h0F, "R8");
        wr(6, 8'hFF); rd_chk(6, 8'h1F, "R8");
        wr(9, 8'hFF); rd_chk(9, 8'h1F, "R8");
        wr(13, 8'hAA); rd_chk(13, 0, "R8");
        rd_chk(7, 8'h3E, "R8"); rd_chk(0, 1, "R8");
        wr(1, 0); wr(9, 3);

        // R4: noise on channel A only, several periods
        cur_req = "R4";
        wr(7, 8'h37);
        wr(6, 1);  idle(3000);
        wr(6, 0);  idle(1500);
        wr(6, 3);  idle(3000);
        wr(6, 31); idle(4000);

        // R5: mixer combinations on all channels
        cur_req = "R5";
        wr(6, 2);
        for (int m = 0; m < 64; m++) begin
            wr(7, m);
            idle(150);
        end

        // R6: envelope mode with ignored low bits
        cur_req = "R6";
        wr(7, 8'h3E); wr(0, 4);
        wr(8, 8'h1A);
        for (int k = 0; k < 400; k++) begin
            @(posedge clk); #1 env_level = 5'(k * 7);
        end
        wr(8, 8'h15); idle(200);
        wr(8, 8'h06); idle(200);

        // R7: direction bits do not change sound
        cur_req = "R7";
        wr(7, 8'hFE); idle(2);
        chk(port_a_out == 1 && port_b_out == 1, "R7", "dirs both out",
            {port_b_out, port_a_out}, 3);
        idle(300);
        wr(7, 8'h7E); idle(2);
        chk(port_a_out == 1 && port_b_out == 0, "R7", "dir A out only",
            {port_b_out, port_a_out}, 1);
        idle(300);
        wr(7, 8'h3E);

        // R9: period shortened at each prescaler phase
        cur_req = "R9";
        for (int ph = 0; ph < 8; ph++) begin
            wr(0, 200); wr(1, 0);
            idle(600 + ph);
            wr(0, 2);
            idle(100);
        end
        measure(16, "R9");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule